// File: doc/BRIEF.md
# Timer-Paced Serial Frame Master

This block is the host end of a 16-bit full-duplex serial link to a sampling converter. It runs on the system clock. From that clock it makes three things: a free-running serial clock, a periodic sample timer, and an active-low frame select that drives the converter's chip select. Each time the timer expires, the block shifts a 16-bit control word out and shifts a 16-bit result word in at the same time. It then presents the received word on a parallel bus together with a one-cycle valid strobe.

A frame request is not acted on at once. The block first waits until the serial clock has gone high, then low, then high again. Because of this wait, frame start times slide relative to the timer whenever the timer period is not a whole number of serial clock periods. A timer expiry that lands while a frame is waiting or running is held in a single pending slot and starts the next frame. The divider value, the reload value and the control word are plain inputs. They are expected to stay constant while the block is out of reset, except that the control word may change between frames.

Top module: `frame_pacer`

## Requirements
- R1: After reset, the serial clock `sclk_o` is low. It is free-running with a 50 % duty cycle and a period of 2*(`div_i`+1) system clocks. Its first rising edge becomes visible `div_i`+1 cycles after the internal reset releases.
- R2: The sample timer expires every `reload_i`+1 system clocks. The first expiry falls in cycle `reload_i` after reset release, and each expiry posts one frame request.
- R3: A posted request starts a frame only after the serial clock has shown a rising, a falling and another rising transition, counted from the cycle after the request is accepted. `fs_n_o` goes low in the same cycle as that second rising edge. As a result, the delay from expiry to frame start varies from frame to frame.
- R4: `fs_n_o` stays low for exactly 16 falling edges of `sclk_o` and returns high together with the 16th falling edge.
- R5: `sdo_o` carries the control word, MSB first. The word is captured when the frame starts. Bit 15 is on the line from frame start, and the line moves to the next bit only at a falling edge of `sclk_o`.
- R6: `sdi_i` is sampled at each falling edge of `sclk_o` during a frame. The first sample becomes bit 15 of `rx_word_o` and the 16th becomes bit 0, so the word is right-justified over 16 bits.
- R7: `rx_valid_o` is a single-cycle pulse that appears only together with the rising edge of `fs_n_o`. `rx_word_o` carries the new word from that cycle and holds it until the next frame completes.
- R8: A timer expiry that arrives while a frame is waiting or running is held pending, not dropped. The next frame then follows after the next rise-fall-rise sequence, with no further timer expiry needed.
- R9: While reset is asserted, `fs_n_o` is high, and `sclk_o`, `sdo_o`, `rx_valid_o` and `rx_word_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| div_i | input | DIV_W | Serial clock divider; half period is div_i+1 system clocks |
| reload_i | input | TMR_W | Sample timer reload; period is reload_i+1 system clocks |
| ctrl_word_i | input | WORD_W | Control word sent in each frame |
| sdi_i | input | 1 | Serial data from the converter |
| sclk_o | output | 1 | Serial clock |
| fs_n_o | output | 1 | Active-low frame select (converter chip select) |
| sdo_o | output | 1 | Serial data to the converter |
| rx_word_o | output | WORD_W | Last received word |
| rx_valid_o | output | 1 | One-cycle strobe marking a new rx_word_o |

## Verification
The bench sweeps every divider value from 0 to 3 and pairs each with sparse reload values. These reloads leave the frames fully separated, so each frame start can be predicted to the exact cycle from the timer arithmetic and the serial clock phase. Because these reloads are not whole multiples of the serial clock period, the expiry-to-start delay must take at least two distinct values; a design that skips the rise-fall-rise wait, or that keeps frames locked to the timer, fails this check. Two dense reloads make the timer fire several times per frame, which separates a design that holds a pending request from one that drops it. Each frame uses a fresh control word and a fresh slave reply, so a shift in the wrong direction, an off-by-one bit count or a sample taken on the wrong edge all show up in the compared words.

// File: rtl/frame_pacer_pkg.sv
package frame_pacer_pkg;

  typedef enum logic [2:0] {
    FP_IDLE   = 3'd0,
    FP_SEEK_H = 3'd1,
    FP_SEEK_L = 3'd2,
    FP_SEEK_R = 3'd3,
    FP_XFER   = 3'd4
  } fp_state_e;

endpackage

// File: rtl/fp_sclk_div.sv
module fp_sclk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  output logic             sclk_o,
  output logic             rise_evt_o,
  output logic             fall_evt_o
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             sclk_q, sclk_d;
  logic             tick;

  always_comb begin
    tick   = (cnt_q >= div_i);
    cnt_d  = tick ? '0 : cnt_q + 1'b1;
    sclk_d = tick ? ~sclk_q : sclk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk_o     = sclk_q;
  assign rise_evt_o = tick & ~sclk_q;
  assign fall_evt_o = tick & sclk_q;

  AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= div_i); // R1

  AST_HALF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_q != $past(sclk_q)) |-> (cnt_q == '0)); // R1

endmodule

// File: rtl/fp_sample_timer.sv
module fp_sample_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TMR_W-1:0] reload_i,
  output logic             expire_o
);

  logic [TMR_W-1:0] cnt_q, cnt_d;
  logic             wrap;

  always_comb begin
    wrap  = (cnt_q >= reload_i);
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign expire_o = wrap;

  AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= reload_i); // R2

  AST_TMR_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && reload_i != '0) |=> !expire_o); // R2

endmodule

// File: rtl/fp_frame_ctl.sv
module fp_frame_ctl
  import frame_pacer_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              expire_i,
  input  logic              rise_evt_i,
  input  logic              fall_evt_i,
  input  logic [WORD_W-1:0] ctrl_word_i,
  input  logic              sdi_i,
  output logic              fs_n_o,
  output logic              sdo_o,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              rx_valid_o
);

  localparam int BIT_W = $clog2(WORD_W + 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  fp_state_e         state_q, state_d;
  logic              pend_q, pend_d;
  logic [WORD_W-1:0] tx_q, tx_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic              fs_n_q, fs_n_d;
  logic              valid_q, valid_d;
  logic              take_req;

  always_comb begin
    state_d  = state_q;
    tx_d     = tx_q;
    sh_d     = sh_q;
    word_d   = word_q;
    bit_d    = bit_q;
    fs_n_d   = fs_n_q;
    valid_d  = 1'b0;
    take_req = 1'b0;
    unique case (state_q)
      FP_IDLE: begin
        if (pend_q) begin
          take_req = 1'b1;
          state_d  = FP_SEEK_H;
        end
      end
      FP_SEEK_H: begin
        if (rise_evt_i) state_d = FP_SEEK_L;
      end
      FP_SEEK_L: begin
        if (fall_evt_i) state_d = FP_SEEK_R;
      end
      FP_SEEK_R: begin
        if (rise_evt_i) begin
          state_d = FP_XFER;
          fs_n_d  = 1'b0;
          tx_d    = ctrl_word_i;
          bit_d   = '0;
        end
      end
      FP_XFER: begin
        if (fall_evt_i) begin
          sh_d  = {sh_q[WORD_W-2:0], sdi_i};
          tx_d  = {tx_q[WORD_W-2:0], 1'b0};
          bit_d = bit_q + 1'b1;
          if (bit_q == LAST_BIT) begin
            state_d = FP_IDLE;
            fs_n_d  = 1'b1;
            word_d  = {sh_q[WORD_W-2:0], sdi_i};
            valid_d = 1'b1;
          end
        end
      end
      default: state_d = FP_IDLE;
    endcase
    pend_d = take_req ? expire_i : (pend_q | expire_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FP_IDLE;
      pend_q  <= 1'b0;
      tx_q    <= '0;
      sh_q    <= '0;
      word_q  <= '0;
      bit_q   <= '0;
      fs_n_q  <= 1'b1;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      tx_q    <= tx_d;
      sh_q    <= sh_d;
      word_q  <= word_d;
      bit_q   <= bit_d;
      fs_n_q  <= fs_n_d;
      valid_q <= valid_d;
    end
  end

  assign fs_n_o     = fs_n_q;
  assign sdo_o      = tx_q[WORD_W-1];
  assign rx_word_o  = word_q;
  assign rx_valid_o = valid_q;

  AST_BITCNT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    bit_q <= BIT_W'(WORD_W)); // R4

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q); // R7

  AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && state_q != FP_IDLE) |=> pend_q); // R8

  AST_SDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!fs_n_q && !$fell(fs_n_q) && !$past(fall_evt_i)) |-> $stable(sdo_o)); // R5

endmodule

// File: rtl/frame_pacer.sv
module frame_pacer #(
  parameter int DIV_W    = 8,
  parameter int TMR_W    = 16,
  parameter int WORD_W   = 16,
  parameter int SYNC_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [TMR_W-1:0]  reload_i,
  input  logic [WORD_W-1:0] ctrl_word_i,
  input  logic              sdi_i,
  output logic              sclk_o,
  output logic              fs_n_o,
  output logic              sdo_o,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              rx_valid_o
);

  logic [SYNC_LEN-1:0] sync_q;
  logic                rst_int_n;
  logic                rise_evt, fall_evt, expire;

  generate
    if (SYNC_LEN == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= 1'b1;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_LEN-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_int_n = sync_q[SYNC_LEN-1];

  fp_sclk_div #(.DIV_W(DIV_W)) u_div (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .div_i      (div_i),
    .sclk_o     (sclk_o),
    .rise_evt_o (rise_evt),
    .fall_evt_o (fall_evt)
  );

  fp_sample_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .reload_i (reload_i),
    .expire_o (expire)
  );

  fp_frame_ctl #(.WORD_W(WORD_W)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .expire_i    (expire),
    .rise_evt_i  (rise_evt),
    .fall_evt_i  (fall_evt),
    .ctrl_word_i (ctrl_word_i),
    .sdi_i       (sdi_i),
    .fs_n_o      (fs_n_o),
    .sdo_o       (sdo_o),
    .rx_word_o   (rx_word_o),
    .rx_valid_o  (rx_valid_o)
  );

  AST_FS_ON_RISE: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(fs_n_o) |-> $rose(sclk_o)); // R3

  AST_FS_END_ON_FALL: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(fs_n_o) |-> $fell(sclk_o)); // R4

  AST_VALID_AT_END: assert property (@(posedge clk) disable iff (!rst_int_n)
    rx_valid_o |-> $rose(fs_n_o)); // R7

endmodule

// File: tb/test_frame_pacer.sv
module test_frame_pacer;

  logic        clk;
  logic        rst_n;
  logic [7:0]  div_i;
  logic [15:0] reload_i;
  logic [15:0] ctrl_word_i;
  logic        sdi_i;
  logic        sclk_o, fs_n_o, sdo_o, rx_valid_o;
  logic [15:0] rx_word_o;

  frame_pacer i_frame_pacer (
    .clk(clk), .rst_n(rst_n), .div_i(div_i), .reload_i(reload_i),
    .ctrl_word_i(ctrl_word_i), .sdi_i(sdi_i), .sclk_o(sclk_o),
    .fs_n_o(fs_n_o), .sdo_o(sdo_o), .rx_word_o(rx_word_o),
    .rx_valid_o(rx_valid_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int total = 0;
  bit done = 0;
  bit sparse = 0;
  bit mon_on = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    total <= total + 1;
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  // monitor and slave model state
  logic p_sclk, p_fs, p_sdo, p_valid;
  int last_rise, frames, bitn, first_dly, gap_start;
  bit dly_differs, in_frame;
  logic [15:0] tx_acc, exp_ctrl, pat;

  function automatic logic [15:0] pat_of(input int k, input int d);
    return 16'h8001 ^ 16'(k * 16'h2F1D) ^ 16'(d * 16'h0470);
  endfunction

  always @(negedge clk) begin
    int d, h, per, e, c, m, r1, s;
    if (!rst_n || !mon_on) begin
      p_sclk = 1'b0; p_fs = 1'b1; p_sdo = 1'b0; p_valid = 1'b0;
      last_rise = -1; frames = 0; bitn = 0; first_dly = -1;
      dly_differs = 0; in_frame = 0; gap_start = -1; sdi_i = 1'b0;
    end else if (cyc >= 2) begin
      d   = cyc - 2;
      h   = int'(div_i) + 1;
      per = 2 * h;
      // R1: serial clock period and phase
      if (!p_sclk && sclk_o) begin
        if (last_rise < 0) chk(d == h, "R1 first rise", d, h);
        else               chk(d - last_rise == per, "R1 period", d - last_rise, per);
        last_rise = d;
      end
      // frame start
      if (p_fs && !fs_n_o) begin
        chk(!p_sclk && sclk_o, "R3 start with sclk rise", sclk_o, 1);
        if (sparse) begin
          e = int'(reload_i) + frames * (int'(reload_i) + 1);
          c = e + 2;
          m = (c > h - 1) ? (c - (h - 1) + per - 1) / per : 0;
          r1 = (h - 1) + per * m;
          s = r1 + per + 1;
          chk(d == s, "R2/R3 start cycle", d, s);
          if (first_dly < 0) first_dly = d - e;
          else if (d - e != first_dly) dly_differs = 1;
        end else if (gap_start >= 0) begin
          chk(d - gap_start <= 2 * per + 3, "R8 pending frame follows", d - gap_start, 2 * per + 3);
        end
        exp_ctrl = ctrl_word_i;
        chk(sdo_o == ctrl_word_i[15], "R5 msb at start", sdo_o, ctrl_word_i[15]);
        pat = pat_of(frames, int'(div_i));
        sdi_i = pat[15];
        bitn = 0; tx_acc = '0; in_frame = 1;
      end
      // falling edges inside a frame
      if (in_frame && !p_fs && p_sclk && !sclk_o) begin
        tx_acc = {tx_acc[14:0], p_sdo};
        bitn++;
        if (bitn < 16) sdi_i = pat[15 - bitn];
      end
      if (in_frame && !p_fs && !fs_n_o && !(p_sclk && !sclk_o) && (sdo_o != p_sdo))
        chk(0, "R5 sdo moved off falling edge", sdo_o, p_sdo);
      // frame end
      if (in_frame && !p_fs && fs_n_o) begin
        chk(bitn == 16, "R4 falling edges per frame", bitn, 16);
        chk(p_sclk && !sclk_o, "R4 end with sclk fall", sclk_o, 0);
        chk(tx_acc == exp_ctrl, "R5 control word", tx_acc, exp_ctrl);
        chk(rx_valid_o == 1'b1, "R7 valid at end", rx_valid_o, 1);
        chk(rx_word_o == pat, "R6 received word", rx_word_o, pat);
        frames++; in_frame = 0; gap_start = d;
        ctrl_word_i = 16'hA5C3 ^ 16'(frames * 16'h1357) ^ 16'(int'(div_i) << 12);
      end else if (rx_valid_o) begin
        chk(0, "R7 stray valid", rx_valid_o, 0);
      end
      if (p_valid && rx_valid_o) chk(0, "R7 valid width", 2, 1);
      if (!in_frame && frames > 0 && !rx_valid_o)
        if (rx_word_o != pat) chk(0, "R7 word held", rx_word_o, pat);
      p_sclk = sclk_o; p_fs = fs_n_o; p_sdo = sdo_o; p_valid = rx_valid_o;
    end
  end

  task automatic run_cfg(input int dv, input int rl, input bit sp, input int ncyc);
    mon_on = 0;
    rst_n = 1'b0;
    div_i = 8'(dv);
    reload_i = 16'(rl);
    sparse = sp;
    ctrl_word_i = 16'hA5C3 ^ 16'(dv << 12);
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(fs_n_o == 1'b1, "R9 fs_n in reset", fs_n_o, 1);
    chk(sclk_o == 1'b0 && sdo_o == 1'b0, "R9 sclk/sdo in reset", {sclk_o, sdo_o}, 0);
    chk(rx_valid_o == 1'b0 && rx_word_o == '0, "R9 rx in reset", rx_word_o, 0);
    mon_on = 1;
    rst_n = 1'b1;
    repeat (ncyc) @(negedge clk);
    chk(frames >= 3, "R2/R8 frame count", frames, 3);
    if (sp) chk(dly_differs, "R3 start drift", dly_differs, 1);
  endtask

  initial begin
    rst_n = 1'b0; div_i = '0; reload_i = '0; ctrl_word_i = '0; sdi_i = 1'b0;
    run_cfg(0, 60, 1, 6 * 61 + 300);
    run_cfg(1, 120, 1, 6 * 121 + 300);
    run_cfg(2, 200, 1, 6 * 201 + 300);
    run_cfg(3, 803, 1, 5 * 804 + 400);
    run_cfg(0, 20, 0, 1500);
    run_cfg(2, 40, 0, 1500);
    done = 1;
  end

  initial begin
    wait (done || total > 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", total, 150000);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule